// File: doc/BRIEF.md
# Effective Address Generation Unit

This combinational unit forms the memory or jump target for one instruction word. It looks at the 4-bit opcode in the top bits of the instruction. It then picks the addend base, either the incremented program counter or a register value that the register file supplies. It also picks the offset: a sign-extended 6-, 9- or 11-bit field of the instruction, or zero. One shared adder produces the sum.

A second path bypasses the adder and zero-extends the low byte of the instruction into a vector-table address. A select output tells the memory address register which of the two addresses to load. A flag output marks instructions whose computed address is only a pointer, so the control sequencer can schedule a second memory read.

The program counter input is the address of the current instruction plus one. All PC-relative offsets therefore count from the next instruction. Register reads and memory cycles belong to the surrounding datapath.

Top module: `ea_gen`

## Requirements
- R1: For opcodes 0010, 0011 and 1110, `addr_o` equals `pc_next_i` plus instruction bits [8:0] read as a two's-complement value. `indirect_o` is 0 and `mar_src_o` is 0.
- R2: For opcodes 1010 and 1011, `addr_o` is the pointer address `pc_next_i` plus the signed bits [8:0], and `indirect_o` is 1. For every other opcode, `indirect_o` is 0.
- R3: For opcodes 0110 and 0111, `addr_o` equals `base_val_i` plus the signed bits [5:0]. That offset spans -32 to +31.
- R4: For opcode 0000, `addr_o` equals `pc_next_i` plus the signed bits [8:0]. The 9-bit offset spans -256 to +255.
- R5: For opcode 0100 with bit 11 set, `addr_o` equals `pc_next_i` plus the signed bits [10:0].
- R6: For opcode 1100, and for opcode 0100 with bit 11 clear, `addr_o` equals `base_val_i` unchanged.
- R7: `vector_o` always equals bits [7:0] zero-extended to 16 bits. `mar_src_o` is 1 exactly for opcode 1111, where 1 means the vector and 0 means the adder.
- R8: For opcodes 0001, 0101, 1000, 1001 and 1101, `addr_o` equals `pc_next_i`, and both `indirect_o` and `mar_src_o` are 0.
- R9: The addition wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word; opcode in bits [15:12] |
| pc_next_i | input | 16 | Address of the instruction plus one |
| base_val_i | input | 16 | Contents of the base register named by bits [8:6] |
| addr_o | output | 16 | Adder result: effective, pointer or jump address |
| vector_o | output | 16 | Zero-extended vector-table address |
| mar_src_o | output | 1 | 1 selects `vector_o` for the memory address register |
| indirect_o | output | 1 | 1 when the address is a pointer needing a second read |

## Verification
The in-line checks assume the instruction, program counter and base value are settled 2-state values whenever they are evaluated. The bench applies every input change on the falling clock edge and compares only on the rising edge, so each comparison sees settled logic. The stimulus uses every defined opcode. It drives the extreme offsets of each field width. It also uses program counter and base values near the top of the address space, which forces the sum to wrap through zero.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

   localparam logic [3:0] OPC_BRANCH  = 4'b0000;
   localparam logic [3:0] OPC_ADD     = 4'b0001;
   localparam logic [3:0] OPC_LD_PC   = 4'b0010;
   localparam logic [3:0] OPC_ST_PC   = 4'b0011;
   localparam logic [3:0] OPC_CALL    = 4'b0100;
   localparam logic [3:0] OPC_AND     = 4'b0101;
   localparam logic [3:0] OPC_LD_BASE = 4'b0110;
   localparam logic [3:0] OPC_ST_BASE = 4'b0111;
   localparam logic [3:0] OPC_RET_INT = 4'b1000;
   localparam logic [3:0] OPC_NOT     = 4'b1001;
   localparam logic [3:0] OPC_LD_IND  = 4'b1010;
   localparam logic [3:0] OPC_ST_IND  = 4'b1011;
   localparam logic [3:0] OPC_JUMP    = 4'b1100;
   localparam logic [3:0] OPC_RSVD    = 4'b1101;
   localparam logic [3:0] OPC_ADDR_PC = 4'b1110;
   localparam logic [3:0] OPC_VECTOR  = 4'b1111;

   typedef enum logic {
      BASE_PC  = 1'b0,
      BASE_REG = 1'b1
   } base_src_e;

   typedef enum logic [1:0] {
      OFS_ZERO  = 2'd0,
      OFS_SHORT = 2'd1,
      OFS_MID   = 2'd2,
      OFS_LONG  = 2'd3
   } ofs_sel_e;

   typedef struct packed {
      base_src_e base;
      ofs_sel_e  ofs;
      logic      indirect;
      logic      vector;
   } ea_ctl_t;

endpackage

// File: rtl/ea_gen_decode.sv
module ea_gen_decode
   import ea_gen_pkg::*;
(
   input  logic [3:0] opc_i,
   input  logic       long_form_i,
   output ea_ctl_t    ctl_o
);

   always_comb begin
      ctl_o          = '0;
      ctl_o.base     = BASE_PC;
      ctl_o.ofs      = OFS_ZERO;
      case (opc_i)
         OPC_BRANCH,
         OPC_LD_PC,
         OPC_ST_PC,
         OPC_ADDR_PC: ctl_o.ofs = OFS_MID;
         OPC_LD_IND,
         OPC_ST_IND: begin
            ctl_o.ofs      = OFS_MID;
            ctl_o.indirect = 1'b1;
         end
         OPC_LD_BASE,
         OPC_ST_BASE: begin
            ctl_o.base = BASE_REG;
            ctl_o.ofs  = OFS_SHORT;
         end
         OPC_CALL: begin
            if (long_form_i) begin
               ctl_o.ofs = OFS_LONG;
            end else begin
               ctl_o.base = BASE_REG;
            end
         end
         OPC_JUMP:   ctl_o.base   = BASE_REG;
         OPC_VECTOR: ctl_o.vector = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/ea_gen_offset.sv
module ea_gen_offset
   import ea_gen_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int SHORT_W = 6,
   parameter int MID_W   = 9,
   parameter int LONG_W  = 11
) (
   input  logic [LONG_W-1:0] fld_i,
   input  ofs_sel_e          sel_i,
   output logic [DATA_W-1:0] ofs_o
);

   localparam int N_FORMS = 3;

   function automatic int form_width(input int idx);
      case (idx)
         0:       return SHORT_W;
         1:       return MID_W;
         default: return LONG_W;
      endcase
   endfunction

   if (SHORT_W >= MID_W || MID_W >= LONG_W) begin : g_bad_order
      $error("offset widths must increase strictly");
   end
   if (LONG_W >= DATA_W) begin : g_bad_long
      $error("longest offset must be narrower than the data path");
   end

   logic [DATA_W-1:0] ext [N_FORMS];

   for (genvar g = 0; g < N_FORMS; g++) begin : g_form
      localparam int W = form_width(g);
      assign ext[g] = {{(DATA_W-W){fld_i[W-1]}}, fld_i[W-1:0]};
   end

   always_comb begin
      case (sel_i)
         OFS_SHORT: ofs_o = ext[0];
         OFS_MID:   ofs_o = ext[1];
         OFS_LONG:  ofs_o = ext[2];
         default:   ofs_o = '0;
      endcase
   end

   always_comb begin
      if (sel_i == OFS_SHORT) begin
         assert_short_span_R3: assert ($signed(ofs_o) >= -(2 ** (SHORT_W-1))
                                       && $signed(ofs_o) < (2 ** (SHORT_W-1)))
            else $error("short offset outside its signed span");
      end
      if (sel_i == OFS_MID) begin
         assert_mid_span_R4: assert ($signed(ofs_o) >= -(2 ** (MID_W-1))
                                     && $signed(ofs_o) < (2 ** (MID_W-1)))
            else $error("mid offset outside its signed span");
      end
   end

endmodule

// File: rtl/ea_gen_adder.sv
module ea_gen_adder
   import ea_gen_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] base_i,
   input  base_src_e         src_i,
   input  logic [DATA_W-1:0] ofs_i,
   output logic [DATA_W-1:0] sum_o
);

   logic [DATA_W-1:0] addend;

   always_comb begin
      addend = (src_i == BASE_REG) ? base_i : pc_i;
      sum_o  = addend + ofs_i;
   end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import ea_gen_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int DATA_W  = 16,
   parameter int OPC_W   = 4,
   parameter int SHORT_W = 6,
   parameter int MID_W   = 9,
   parameter int LONG_W  = 11,
   parameter int VEC_W   = 8
) (
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  pc_next_i,
   input  logic [DATA_W-1:0]  base_val_i,
   output logic [DATA_W-1:0]  addr_o,
   output logic [DATA_W-1:0]  vector_o,
   output logic               mar_src_o,
   output logic               indirect_o
);

   localparam int OPC_LSB  = INSTR_W - OPC_W;
   localparam int FORM_BIT = LONG_W;

   if (OPC_W != 4) begin : g_bad_opc
      $error("decoder expects a 4-bit opcode");
   end
   if (FORM_BIT >= OPC_LSB) begin : g_bad_form
      $error("long offset collides with opcode field");
   end
   if (VEC_W > LONG_W || VEC_W >= DATA_W) begin : g_bad_vec
      $error("vector field too wide");
   end

   ea_ctl_t           ctl;
   logic [DATA_W-1:0] ofs;

   ea_gen_decode u_decode (
      .opc_i       (instr_i[INSTR_W-1:OPC_LSB]),
      .long_form_i (instr_i[FORM_BIT]),
      .ctl_o       (ctl)
   );

   ea_gen_offset #(
      .DATA_W  (DATA_W),
      .SHORT_W (SHORT_W),
      .MID_W   (MID_W),
      .LONG_W  (LONG_W)
   ) u_offset (
      .fld_i (instr_i[LONG_W-1:0]),
      .sel_i (ctl.ofs),
      .ofs_o (ofs)
   );

   ea_gen_adder #(
      .DATA_W (DATA_W)
   ) u_adder (
      .pc_i   (pc_next_i),
      .base_i (base_val_i),
      .src_i  (ctl.base),
      .ofs_i  (ofs),
      .sum_o  (addr_o)
   );

   assign vector_o   = {{(DATA_W-VEC_W){1'b0}}, instr_i[VEC_W-1:0]};
   assign mar_src_o  = ctl.vector;
   assign indirect_o = ctl.indirect;

   always_comb begin
      if (indirect_o) begin
         assert_ptr_pc_rel_R2: assert (ctl.base == BASE_PC && ctl.ofs == OFS_MID)
            else $error("pointer address not formed PC-relative");
      end
      if (mar_src_o) begin
         assert_vec_direct_R7: assert (!indirect_o && ctl.ofs == OFS_ZERO)
            else $error("vector select mixed with adder use");
      end
      if (ctl.base == BASE_REG && ctl.ofs == OFS_ZERO) begin
         assert_reg_jump_R6: assert (addr_o == base_val_i)
            else $error("register jump target altered");
      end
   end

endmodule

// File: tb/ea_gen_test.sv
module ea_gen_test;

   typedef struct {
      logic [15:0] addr;
      logic [15:0] vec;
      logic        sel;
      logic        ind;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr = '0;
   logic [15:0] pc_next = '0;
   logic [15:0] base_val = '0;
   logic [15:0] addr, vec;
   logic        sel, ind;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;
   exp_t sb [$];

   always #5 clk = ~clk;

   ea_gen uut (
      .instr_i    (instr),
      .pc_next_i  (pc_next),
      .base_val_i (base_val),
      .addr_o     (addr),
      .vector_o   (vec),
      .mar_src_o  (sel),
      .indirect_o (ind)
   );

   function automatic int sfield(input logic [15:0] w, input int width);
      int v = int'(w) & ((1 << width) - 1);
      if (v >= (1 << (width - 1))) v -= (1 << width);
      return v;
   endfunction

   function automatic exp_t model(input logic [15:0] ir, input logic [15:0] pc,
                                  input logic [15:0] bv, input string tag);
      exp_t e;
      int   a;
      a     = int'(pc);
      e.ind = 1'b0;
      e.sel = 1'b0;
      e.tag = tag;
      e.vec = {8'h00, ir[7:0]};
      case (ir[15:12])
         4'b0000, 4'b0010, 4'b0011, 4'b1110: a = int'(pc) + sfield(ir, 9);
         4'b1010, 4'b1011: begin a = int'(pc) + sfield(ir, 9); e.ind = 1'b1; end
         4'b0110, 4'b0111: a = int'(bv) + sfield(ir, 6);
         4'b0100: a = ir[11] ? int'(pc) + sfield(ir, 11) : int'(bv);
         4'b1100: a = int'(bv);
         4'b1111: e.sel = 1'b1;
         default: a = int'(pc);
      endcase
      e.addr = 16'(a & 32'hFFFF);
      return e;
   endfunction

   task automatic drive(input logic [15:0] ir, input logic [15:0] pc,
                        input logic [15:0] bv, input string tag);
      @(negedge clk);
      instr    = ir;
      pc_next  = pc;
      base_val = bv;
      sb.push_back(model(ir, pc, bv, tag));
   endtask

   always @(posedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_checks++;
         if (addr !== e.addr || vec !== e.vec || sel !== e.sel || ind !== e.ind) begin
            n_fail++;
            $display("FAIL %s: got addr=%h vec=%h sel=%b ind=%b, expected addr=%h vec=%h sel=%b ind=%b",
                     e.tag, addr, vec, sel, ind, e.addr, e.vec, e.sel, e.ind);
         end
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      drive(16'h0000, 16'h0000, 16'h0000, "reset-state R4 zero");
      drive({4'b0010, 3'd2, 9'h005}, 16'h3001, 16'h0, "R1 load direct +5");
      drive({4'b0011, 3'd1, 9'h1FF}, 16'h3001, 16'h0, "R1 store direct -1");
      drive({4'b1110, 3'd5, 9'h0FF}, 16'h4000, 16'h0, "R1 address +255");
      drive({4'b1110, 3'd5, 9'h100}, 16'h4000, 16'h0, "R1 address -256");
      drive({4'b1010, 3'd3, 9'h1C3}, 16'h2081, 16'h0, "R2 load indirect");
      drive({4'b1011, 3'd3, 9'h010}, 16'h2081, 16'h0, "R2 store indirect");
      drive({4'b0110, 3'd1, 3'd6, 6'h0C}, 16'h1111, 16'h2035, "R3 base +12");
      drive({4'b0111, 3'd2, 3'd4, 6'h1F}, 16'h1111, 16'h5000, "R3 base +31");
      drive({4'b0110, 3'd2, 3'd4, 6'h20}, 16'h1111, 16'h5000, "R3 base -32");
      drive({4'b0000, 3'b010, 9'h0D9}, 16'h3010, 16'h0, "R4 branch +217");
      drive({4'b0000, 3'b111, 9'h180}, 16'h3010, 16'h0, "R4 branch -128");
      drive({4'b0100, 1'b1, 11'h3FF}, 16'h6000, 16'h0, "R5 call +1023");
      drive({4'b0100, 1'b1, 11'h400}, 16'h6000, 16'h0, "R5 call -1024");
      drive({4'b0100, 1'b0, 2'b00, 3'd5, 6'h3F}, 16'h6000, 16'h3500, "R6 call via reg");
      drive({4'b1100, 3'd0, 3'd5, 6'h3F}, 16'h6000, 16'hBEEF, "R6 reg jump");
      drive({4'b1111, 4'h0, 8'h25}, 16'h7000, 16'h1234, "R7 vector x25");
      drive({4'b1111, 4'h0, 8'hFF}, 16'h7000, 16'h1234, "R7 vector xFF");
      drive({4'b0001, 3'd1, 3'd2, 6'h3F}, 16'h0101, 16'h2222, "R8 add passes PC");
      drive({4'b0101, 12'hFFF}, 16'h0202, 16'h2222, "R8 and passes PC");
      drive({4'b1001, 12'hABC}, 16'h0303, 16'h2222, "R8 not passes PC");
      drive({4'b1000, 12'h000}, 16'h0404, 16'h2222, "R8 return passes PC");
      drive({4'b1101, 12'h5A5}, 16'h0505, 16'h2222, "R8 reserved passes PC");
      drive({4'b0010, 3'd0, 9'h001}, 16'hFFFF, 16'h0, "R9 PC wrap");
      drive({4'b0111, 3'd0, 3'd1, 6'h1F}, 16'hFFFF, 16'hFFF0, "R9 base wrap");
      drive({4'b0000, 3'd0, 9'h100}, 16'h0010, 16'h0, "R9 PC underflow");
      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
      end
      #1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule